// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block watches the address channels of a memory-like AXI subordinate and decides, for every exclusive write, whether the write may complete with EXOKAY or must fall back to OKAY. Each exclusive read (lock bit set) leaves a reservation in a slot selected by its transaction ID. The slot holds the read's start address, its beat size and the byte span its burst covers. The subordinate's write-response logic uses the registered pass flag to choose the B response. Data storage and the decision to suppress a failed exclusive write stay outside this block.

Reservations are dropped in two ways. An exclusive write from the owning ID always consumes its own slot, whether it matched or not. Any write from any ID whose byte span overlaps a reserved span also clears that slot. Matching for success is strict: the ID, the start address and the beat size must all be equal. The burst length of either side plays no part in the match. A global enable turns the whole function off, so that exclusive writes then always see a normal response.

Top module: `excl_mon`

## Requirements
- R1: After an exclusive read (rd_lock=1) from ID n at address A with size S, an exclusive write (wr_lock=1) from ID n at address A with size S gives wr_excl_pass=1 in the cycle after the write is observed.
- R2: An exclusive write consumes its ID's reservation. A second identical exclusive write, with no new exclusive read in between, gives wr_excl_pass=0.
- R3: An exclusive write with the reserved ID and address but a different size, smaller or larger, gives 0 and clears that reservation.
- R4: An exclusive write from the reserved ID to a different start address gives 0 and clears that reservation.
- R5: A write from another ID, with or without lock, clears a reservation when its byte span meets the reserved span. Spans are computed from the burst field: FIXED (0) covers one beat from the address. INCR (1) covers (len+1)<<size bytes from the address. WRAP (2) covers the same number of bytes, aligned down to that total.
- R6: A write from another ID whose span does not meet the reserved span, including one that only touches the byte after it, leaves the reservation intact.
- R7: A new exclusive read from an ID replaces that ID's earlier reservation. Only the newest address can then succeed.
- R8: Matching uses the start address only. A burst read followed by a single-beat write at the start address passes. A single read followed by a burst write at the same start passes. A write aimed at the second beat of a reserved burst fails.
- R9: While enable=0, wr_excl_pass stays 0 and exclusive reads record nothing.
- R10: Synchronous reset clears every reservation and drives wr_resp_valid and wr_excl_pass to 0.
- R11: wr_resp_valid is 1 exactly in the cycle after each observed write, and wr_excl_pass is 1 only when that write had lock set.
- R12: A read with rd_lock=0 records no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Turns exclusive tracking on |
| rd_valid | input | 1 | Read address accepted this cycle |
| rd_id | input | ID_W | Read transaction ID |
| rd_addr | input | ADDR_W | Read start address |
| rd_size | input | 3 | Read beat size, log2 bytes |
| rd_len | input | 8 | Read beats minus one |
| rd_burst | input | 2 | Read burst type |
| rd_lock | input | 1 | Read is exclusive |
| wr_valid | input | 1 | Write address accepted this cycle |
| wr_id | input | ID_W | Write transaction ID |
| wr_addr | input | ADDR_W | Write start address |
| wr_size | input | 3 | Write beat size, log2 bytes |
| wr_len | input | 8 | Write beats minus one |
| wr_burst | input | 2 | Write burst type |
| wr_lock | input | 1 | Write is exclusive |
| wr_resp_valid | output | 1 | Decision for the previous cycle's write is ready |
| wr_excl_pass | output | 1 | Previous write may answer EXOKAY |

## Verification
The hardest case to reach is a reservation that must survive a write that comes very close to it. Examples are a write from another ID that starts on the byte just past an INCR span, and a FIXED burst whose long length must not widen its footprint. The stimulus builds these with a reservation, then the neighbouring write, then the owner's exclusive write. Only a passing final write shows that the slot survived. WRAP alignment and clears by partial overlap are reached the same way, with the owner's write expected to fail.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    localparam int SIZE_W  = 3;
    localparam int LEN_W   = 8;
    localparam int BURST_W = 2;

    typedef enum logic [BURST_W-1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    // number of bytes touched by a whole burst
    function automatic logic [31:0] burst_bytes(input logic [SIZE_W-1:0] size,
                                                input logic [LEN_W-1:0]  len);
        return (32'(len) + 32'd1) << size;
    endfunction

endpackage

// File: rtl/excl_span.sv
module excl_span
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SIZE_W-1:0]  size,
    input  logic [LEN_W-1:0]   len,
    input  logic [BURST_W-1:0] burst,
    output logic [ADDR_W:0]    lo,
    output logic [ADDR_W:0]    hi
);
    localparam int SPAN_W = ADDR_W + 1;

    logic [SPAN_W-1:0] base;
    logic [SPAN_W-1:0] beat;
    logic [SPAN_W-1:0] total;

    always_comb begin
        base  = {1'b0, addr};
        beat  = SPAN_W'(1) << size;
        total = SPAN_W'(burst_bytes(size, len));
        unique case (burst_e'(burst))
            BURST_FIXED: begin
                lo = base;
                hi = base + beat - SPAN_W'(1);
            end
            BURST_WRAP: begin
                lo = base & ~(total - SPAN_W'(1));
                hi = lo + total - SPAN_W'(1);
            end
            default: begin
                lo = base;
                hi = base + total - SPAN_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/excl_entry.sv
module excl_entry
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [SIZE_W-1:0] set_size,
    input  logic [ADDR_W:0]   set_lo,
    input  logic [ADDR_W:0]   set_hi,
    input  logic              wr_valid,
    input  logic              wr_own_excl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [ADDR_W:0]   wr_lo,
    input  logic [ADDR_W:0]   wr_hi,
    output logic              hit
);
    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [ADDR_W:0]   lo_q;
    logic [ADDR_W:0]   hi_q;
    logic              overlap;
    logic              clear;

    assign hit     = vld_q && (addr_q == wr_addr) && (size_q == wr_size);
    assign overlap = vld_q && !((wr_hi < lo_q) || (wr_lo > hi_q));
    assign clear   = wr_valid && (wr_own_excl || overlap);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            size_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (set) begin
            vld_q  <= 1'b1;
            addr_q <= set_addr;
            size_q <= set_size;
            lo_q   <= set_lo;
            hi_q   <= set_hi;
        end else if (clear) begin
            vld_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/excl_mon.sv
module excl_mon
    import excl_mon_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               rd_valid,
    input  logic [ID_W-1:0]    rd_id,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [SIZE_W-1:0]  rd_size,
    input  logic [LEN_W-1:0]   rd_len,
    input  logic [BURST_W-1:0] rd_burst,
    input  logic               rd_lock,
    input  logic               wr_valid,
    input  logic [ID_W-1:0]    wr_id,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [SIZE_W-1:0]  wr_size,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic [BURST_W-1:0] wr_burst,
    input  logic               wr_lock,
    output logic               wr_resp_valid,
    output logic               wr_excl_pass
);
    localparam int NUM_ID = 1 << ID_W;

    logic [ADDR_W:0]   rd_lo, rd_hi, wr_lo, wr_hi;
    logic [NUM_ID-1:0] hit;
    logic              pass_d;

    excl_span #(.ADDR_W(ADDR_W)) u_rd_span (
        .addr(rd_addr), .size(rd_size), .len(rd_len), .burst(rd_burst),
        .lo(rd_lo), .hi(rd_hi)
    );

    excl_span #(.ADDR_W(ADDR_W)) u_wr_span (
        .addr(wr_addr), .size(wr_size), .len(wr_len), .burst(wr_burst),
        .lo(wr_lo), .hi(wr_hi)
    );

    for (genvar g = 0; g < NUM_ID; g++) begin : g_slot
        logic set_g;
        logic own_g;
        assign set_g = rd_valid && rd_lock && enable && (rd_id == ID_W'(g));
        assign own_g = wr_lock && (wr_id == ID_W'(g));

        excl_entry #(.ADDR_W(ADDR_W)) u_entry (
            .clk        (clk),
            .rst        (rst),
            .set        (set_g),
            .set_addr   (rd_addr),
            .set_size   (rd_size),
            .set_lo     (rd_lo),
            .set_hi     (rd_hi),
            .wr_valid   (wr_valid),
            .wr_own_excl(own_g),
            .wr_addr    (wr_addr),
            .wr_size    (wr_size),
            .wr_lo      (wr_lo),
            .wr_hi      (wr_hi),
            .hit        (hit[g])
        );
    end

    assign pass_d = wr_valid && wr_lock && enable && hit[wr_id];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_resp_valid <= 1'b0;
            wr_excl_pass  <= 1'b0;
        end else begin
            wr_resp_valid <= wr_valid;
            wr_excl_pass  <= pass_d;
        end
    end

endmodule

// File: rtl/excl_mon_checker.sv
module excl_mon_checker #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            enable,
    input logic            rd_valid,
    input logic [ID_W-1:0] rd_id,
    input logic            rd_lock,
    input logic            wr_valid,
    input logic [ID_W-1:0] wr_id,
    input logic            wr_lock,
    input logic            wr_resp_valid,
    input logic            wr_excl_pass
);
    localparam int NUM_ID = 1 << ID_W;

    logic [NUM_ID-1:0] seen_q;
    logic              seen_cur;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else if (rd_valid && rd_lock && enable) seen_q[rd_id] <= 1'b1;
    end
    assign seen_cur = seen_q[wr_id];

    // R11: every observed write gets a decision one cycle later
    p_resp_follows_write_r11: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> wr_resp_valid);

    // R11: no decision without a write the cycle before
    p_no_spurious_resp_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !wr_resp_valid);

    // R11: pass only for a locked write
    p_pass_needs_lock_r11: assert property (@(posedge clk) disable iff (rst)
        wr_excl_pass |-> wr_resp_valid && $past(wr_lock));

    // R9: disabled monitor never passes
    p_disabled_no_pass_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !wr_excl_pass);

    // R10 / R12: a pass needs an exclusive read from that ID since reset
    p_pass_needs_reservation_r10: assert property (@(posedge clk) disable iff (rst)
        wr_excl_pass |-> $past(seen_cur));

    // R10: outputs idle straight after reset
    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> !wr_resp_valid && !wr_excl_pass);

endmodule

bind excl_mon excl_mon_checker #(.ID_W(ID_W)) u_excl_mon_checker (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .rd_valid     (rd_valid),
    .rd_id        (rd_id),
    .rd_lock      (rd_lock),
    .wr_valid     (wr_valid),
    .wr_id        (wr_id),
    .wr_lock      (wr_lock),
    .wr_resp_valid(wr_resp_valid),
    .wr_excl_pass (wr_excl_pass)
);

// File: tb/excl_mon_bench.sv
module excl_mon_bench;

    localparam int ID_W   = 4;
    localparam int ADDR_W = 16;

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  id;
        logic [15:0] addr;
        logic [2:0]  size;
        logic [7:0]  len;
        logic [1:0]  burst;
        logic        lock;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t op(input logic w, input int id, input int a, input int s,
                                input int l, input int b, input logic lk,
                                input logic e, input int r);
        vec_t v;
        v.is_wr = w; v.id = 4'(id); v.addr = 16'(a); v.size = 3'(s);
        v.len = 8'(l); v.burst = 2'(b); v.lock = lk; v.exp = e; v.req = 4'(r);
        return v;
    endfunction

    localparam int NV = 48;
    localparam vec_t TBL [NV] = '{
        op(0,1,'h1000,3,0,1,1,0,1),  op(1,1,'h1000,3,0,1,1,1,1),   // R1
        op(1,1,'h1000,3,0,1,1,0,2),                                 // R2
        op(0,2,'h1000,3,0,1,1,0,3),  op(1,2,'h1000,2,0,1,1,0,3),   // R3 smaller
        op(1,2,'h1000,3,0,1,1,0,3),
        op(0,3,'h1000,0,0,1,1,0,3),  op(1,3,'h1000,2,0,1,1,0,3),   // R3 larger
        op(1,3,'h1000,0,0,1,1,0,3),
        op(0,3,'h1000,0,0,1,1,0,4),  op(1,3,'h2000,2,0,1,1,0,4),   // R4
        op(1,3,'h1000,0,0,1,1,0,4),
        op(0,4,'h1000,3,0,1,1,0,5),  op(1,1,'h1000,3,0,1,1,0,5),   // R5 exact other
        op(1,4,'h1000,3,0,1,1,0,5),
        op(0,5,'h1000,3,0,1,1,0,5),  op(1,2,'h1004,1,0,1,0,0,5),   // R5 partial
        op(1,5,'h1000,3,0,1,1,0,5),
        op(0,0,'h1000,3,0,1,1,0,6),  op(1,1,'h1020,3,0,1,1,0,6),   // R6
        op(1,6,'h1008,3,0,1,0,0,6),  op(1,0,'h1000,3,0,1,1,1,6),
        op(0,0,'h1000,3,0,1,1,0,7),  op(0,0,'h2000,3,0,1,1,0,7),   // R7
        op(1,0,'h1000,3,0,1,1,0,7),
        op(0,0,'h1000,3,0,1,1,0,7),  op(0,0,'h2000,3,0,1,1,0,7),
        op(1,0,'h2000,3,0,1,1,1,7),
        op(0,1,'h1000,3,2,1,1,0,8),  op(1,1,'h1000,3,0,1,1,1,8),   // R8
        op(0,1,'h1000,3,0,1,1,0,8),  op(1,1,'h1000,3,1,2,1,1,8),
        op(0,1,'h1000,3,1,1,1,0,8),  op(1,1,'h1008,3,0,1,1,0,8),
        op(0,7,'h3000,2,0,1,0,0,12), op(1,7,'h3000,2,0,1,1,0,12),  // R12
        op(0,8,'h4000,2,3,1,1,0,5),  op(1,9,'h400C,2,0,1,0,0,5),   // R5 INCR span
        op(1,8,'h4000,2,0,1,1,0,5),
        op(0,8,'h4000,2,3,1,1,0,6),  op(1,9,'h4010,2,0,1,0,0,6),   // R6 byte after
        op(1,8,'h4000,2,0,1,1,1,6),
        op(0,10,'h5008,2,3,2,1,0,5), op(1,11,'h5000,0,0,1,0,0,5),  // R5 WRAP
        op(1,10,'h5008,2,0,1,1,0,5),
        op(0,12,'h6000,2,3,0,1,0,6), op(1,13,'h6004,2,0,1,0,0,6),  // R6 FIXED
        op(1,12,'h6000,2,0,1,1,1,6)
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b1;
    logic              rd_valid = 1'b0, rd_lock = 1'b0;
    logic [ID_W-1:0]   rd_id = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [2:0]        rd_size = '0;
    logic [7:0]        rd_len = '0;
    logic [1:0]        rd_burst = '0;
    logic              wr_valid = 1'b0, wr_lock = 1'b0;
    logic [ID_W-1:0]   wr_id = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [2:0]        wr_size = '0;
    logic [7:0]        wr_len = '0;
    logic [1:0]        wr_burst = '0;
    logic              wr_resp_valid, wr_excl_pass;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    excl_mon #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_excl_mon (
        .clk(clk), .rst(rst), .enable(enable),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_len(rd_len), .rd_burst(rd_burst), .rd_lock(rd_lock),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_len(wr_len), .wr_burst(wr_burst), .wr_lock(wr_lock),
        .wr_resp_valid(wr_resp_valid), .wr_excl_pass(wr_excl_pass)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    // drive one operation for one cycle, then check both outputs
    task automatic apply(input vec_t v, input string req);
        @(negedge clk);
        if (v.is_wr) begin
            wr_valid = 1'b1; wr_id = v.id; wr_addr = v.addr; wr_size = v.size;
            wr_len = v.len; wr_burst = v.burst; wr_lock = v.lock;
        end else begin
            rd_valid = 1'b1; rd_id = v.id; rd_addr = v.addr; rd_size = v.size;
            rd_len = v.len; rd_burst = v.burst; rd_lock = v.lock;
        end
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        check({req, " R11 resp"}, wr_resp_valid, v.is_wr);
        if (v.is_wr) check({req, " pass"}, wr_excl_pass, v.exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs idle in reset
        check("R10 reset resp", wr_resp_valid, 1'b0);
        check("R10 reset pass", wr_excl_pass, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            apply(TBL[i], $sformatf("R%0d vec%0d", TBL[i].req, i));

        // R10: reset drops a live reservation
        apply(op(0,14,'h7000,3,0,1,1,0,10), "R10 setup");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        apply(op(1,14,'h7000,3,0,1,1,0,10), "R10 after reset");

        // R9: disabled monitor refuses a live reservation
        apply(op(0,15,'h7100,3,0,1,1,0,9), "R9 setup");
        enable = 1'b0;
        apply(op(1,15,'h7100,3,0,1,1,0,9), "R9 disabled write");
        // R9: read while disabled records nothing
        apply(op(0,15,'h7200,3,0,1,1,0,9), "R9 disabled read");
        enable = 1'b1;
        apply(op(1,15,'h7200,3,0,1,1,0,9), "R9 enabled write");
        // control: same pattern while enabled passes (R1)
        apply(op(0,15,'h7300,3,0,1,1,0,1), "R1 setup");
        apply(op(1,15,'h7300,3,0,1,1,1,1), "R1 enabled pass");

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual hung expected done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule